// File: doc/BRIEF.md
# Forty-Channel Digital Input Register Port

This block is the bus-facing register window of a digital input module with forty channels. It brings the raw input lines into the clock domain through a two-stage synchronizer per line. It presents the synchronized levels as three read-only channel words in a small I/O address space. It also serves a 32-byte identification table in a separate ID space. A narrow word address selects the location, and two byte-lane enables allow 16-bit or 8-bit reads.

Every access takes one wait state and ends with a one-cycle acknowledge. A run of word addresses is set aside for the interrupt registers. Those registers live in another block, so for that run this port only forwards the decoded index, the write strobe and the read data.

Top module: `dinreg_port`

## Requirements
- R1: Each input line passes through two synchronizing flops. A level applied at the clock edge that begins an access is not yet returned by that access, but is returned by the next access.
- R2: I/O word address 0 returns channels 0 to 15, with bit i equal to channel i (0 = low, 1 = high).
- R3: I/O word address 1 returns channels 16 to 31, with bit i equal to channel 16+i.
- R4: I/O word address 2 returns channels 32 to 39 on bits 7:0, with bit i equal to channel 32+i. Bits 15:8 read as ones.
- R5: I/O word addresses that hold no register (3 and 10 to 63) read 16'h0FFF.
- R6: I/O word addresses 4 to 9 form the interrupt register window. `ext_idx` carries the address minus 4 from the cycle after the select is taken. A read returns `ext_rdata`. A write raises `ext_we` for exactly the acknowledge cycle, with `ext_wdata` and `ext_be` equal to the values driven by the host.
- R7: `be[0]` enables data bits 7:0 and `be[1]` enables bits 15:8. A disabled lane reads as zero, in both spaces.
- R8: In ID space, word address n returns ID byte n on bits 7:0, and bits 15:8 are zero. Byte 0 to 3 hold the ASCII characters "DINP". Byte 4 is vendor 8'h5A. Byte 5 is model code 8'h27. Byte 6 is revision 8'h01. Byte 7 is 8'h00. Byte 8 is driver id low 8'h31. Byte 9 is driver id high 8'h00. Byte 10 is the used-byte count 8'h0C. All other bytes, including word addresses 32 to 63, are 8'h00.
- R9: With the select held, `ack` is low after the first rising edge that samples the select. It is high for exactly one cycle after the second edge. It stays low until the select has been released and asserted again.
- R10: A write to a read-only I/O location or to ID space is acknowledged with normal timing. It returns zero data, leaves `ext_we` low and changes nothing that a later read returns.
- R11: After reset, `ack`, `ext_we` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din_raw | input | NCH (40) | Raw input lines, asynchronous |
| io_sel | input | 1 | Select for I/O space |
| id_sel | input | 1 | Select for ID space |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | ADDR_W (6) | Word address |
| be | input | 2 | Byte-lane enables (bit 0 = low byte) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `ack` is high |
| ack | output | 1 | One-cycle access acknowledge |
| ext_idx | output | XIDX_W (3) | Interrupt register index within the window |
| ext_we | output | 1 | Write strobe for the interrupt register block |
| ext_wdata | output | 16 | Write data forwarded to the interrupt register block |
| ext_be | output | 2 | Byte enables forwarded to the interrupt register block |
| ext_rdata | input | 16 | Read data from the interrupt register block |

## Verification
The select is taken at the first rising edge. The cycle's attributes and `ext_idx` become valid after that edge. Read data, `ack` and `ext_we` appear together after the second edge, so the bench samples them at the falling edge that follows. It confirms that `ack` is low half a cycle before and half a cycle after. A level change on an input needs two edges to reach the read path. Sweeps therefore wait three cycles after changing the inputs. One directed case changes the inputs at the same falling edge the access starts on, and expects the old value first and the new value on the following access.

// File: rtl/dinreg_pkg.sv
package dinreg_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_WAIT = 2'd1,
    BS_ACK  = 2'd2,
    BS_HOLD = 2'd3
  } bus_st_t;

  // Zero the byte lanes that are not enabled.
  function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  // Bits of the last channel word that carry no channel.
  function automatic logic [15:0] pad_mask(input int nch, input int nword);
    logic [15:0] m;
    m = '0;
    for (int b = 0; b < 16; b++)
      if ((nword - 1) * 16 + b >= nch) m[b] = 1'b1;
    return m;
  endfunction

  // Identification byte n; positions past the used ones read zero.
  function automatic logic [7:0] id_byte(input logic [5:0] n, input logic [31:0] tag,
                                         input logic [7:0] vendor, input logic [7:0] model,
                                         input logic [7:0] rev, input logic [15:0] drv,
                                         input logic [7:0] used);
    case (n)
      6'd0:    return tag[31:24];
      6'd1:    return tag[23:16];
      6'd2:    return tag[15:8];
      6'd3:    return tag[7:0];
      6'd4:    return vendor;
      6'd5:    return model;
      6'd6:    return rev;
      6'd8:    return drv[7:0];
      6'd9:    return drv[15:8];
      6'd10:   return used;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/din_sync.sv
module din_sync #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        synced[i] <= 1'b0;
      end else begin
        stage1[i] <= raw[i];
        synced[i] <= stage1[i];
      end
    end
  end

  // R1: the synchronized bit follows the raw line two edges late
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> synced == $past(raw, 2));
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import dinreg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              id_sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        be,
  input  logic [15:0]       wdata,
  output logic              cyc_fin,
  output logic              ack,
  output logic              cyc_io,
  output logic              cyc_wr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_be,
  output logic [15:0]       cyc_wdata
);
  bus_st_t st;
  logic    sel_any;

  assign sel_any = io_sel | id_sel;
  assign cyc_fin = (st == BS_WAIT);
  assign ack     = (st == BS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BS_IDLE;
      cyc_io    <= 1'b0;
      cyc_wr    <= 1'b0;
      cyc_addr  <= '0;
      cyc_be    <= '0;
      cyc_wdata <= '0;
    end else begin
      case (st)
        BS_IDLE: if (sel_any) begin
          st        <= BS_WAIT;
          cyc_io    <= io_sel;
          cyc_wr    <= wr;
          cyc_addr  <= addr;
          cyc_be    <= be;
          cyc_wdata <= wdata;
        end
        BS_WAIT: st <= BS_ACK;
        BS_ACK:  st <= sel_any ? BS_HOLD : BS_IDLE;
        default: if (!sel_any) st <= BS_IDLE;
      endcase
    end
  end

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R9
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(sel_any, 2));
endmodule

// File: rtl/reg_read.sv
module reg_read
  import dinreg_pkg::*;
#(
  parameter int          NCH       = 40,
  parameter int          ADDR_W    = 6,
  parameter int          XBASE     = 4,
  parameter int          NXREG     = 6,
  parameter logic [31:0] ID_TAG    = 32'h44494E50,
  parameter logic [7:0]  ID_VENDOR = 8'h5A,
  parameter logic [7:0]  ID_MODEL  = 8'h27,
  parameter logic [7:0]  ID_REV    = 8'h01,
  parameter logic [15:0] ID_DRV    = 16'h0031,
  parameter logic [7:0]  ID_USED   = 8'h0C
) (
  input  logic [NCH-1:0]    din,
  input  logic              cyc_io,
  input  logic              cyc_wr,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [1:0]        cyc_be,
  input  logic [15:0]       ext_rdata,
  output logic              ext_hit,
  output logic              io_miss,
  output logic [15:0]       rd_word
);
  localparam int NWORD  = (NCH + WORD_W - 1) / WORD_W;
  localparam int WSEL_W = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int NWP    = 1 << WSEL_W;
  localparam logic [ADDR_W-1:0] WLIM = ADDR_W'(NWORD);
  localparam logic [ADDR_W-1:0] XLO  = ADDR_W'(XBASE);
  localparam logic [ADDR_W-1:0] XHI  = ADDR_W'(XBASE + NXREG);

  logic [15:0] words [NWP];

  for (genvar k = 0; k < NWP; k++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_b
      if (k * WORD_W + b < NCH) begin : g_ch
        assign words[k][b] = din[k*WORD_W+b];
      end else begin : g_pad
        assign words[k][b] = 1'b1;
      end
    end
  end

  logic        in_words;
  logic [15:0] raw_word;

  assign in_words = cyc_addr < WLIM;
  assign ext_hit  = cyc_io && (cyc_addr >= XLO) && (cyc_addr < XHI);
  assign io_miss  = cyc_io && !in_words && !ext_hit;

  always_comb begin
    if (!cyc_io)
      raw_word = {8'h00, id_byte(cyc_addr, ID_TAG, ID_VENDOR, ID_MODEL, ID_REV, ID_DRV, ID_USED)};
    else if (in_words)
      raw_word = words[cyc_addr[WSEL_W-1:0]];
    else if (ext_hit)
      raw_word = ext_rdata;
    else
      raw_word = 16'h0FFF;
  end

  assign rd_word = cyc_wr ? 16'h0000 : lane_mask(raw_word, cyc_be);
endmodule

// File: rtl/dinreg_port.sv
module dinreg_port
  import dinreg_pkg::*;
#(
  parameter int          NCH       = 40,
  parameter int          ADDR_W    = 6,
  parameter int          XBASE     = 4,
  parameter int          NXREG     = 6,
  parameter int          XIDX_W    = (NXREG > 1) ? $clog2(NXREG) : 1,
  parameter logic [31:0] ID_TAG    = 32'h44494E50,
  parameter logic [7:0]  ID_VENDOR = 8'h5A,
  parameter logic [7:0]  ID_MODEL  = 8'h27,
  parameter logic [7:0]  ID_REV    = 8'h01,
  parameter logic [15:0] ID_DRV    = 16'h0031,
  parameter logic [7:0]  ID_USED   = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    din_raw,
  input  logic              io_sel,
  input  logic              id_sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        be,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ack,
  output logic [XIDX_W-1:0] ext_idx,
  output logic              ext_we,
  output logic [15:0]       ext_wdata,
  output logic [1:0]        ext_be,
  input  logic [15:0]       ext_rdata
);
  localparam int NWORD = (NCH + WORD_W - 1) / WORD_W;
  localparam logic [ADDR_W-1:0] LASTW = ADDR_W'(NWORD - 1);
  localparam logic [15:0] PADM = pad_mask(NCH, NWORD);
  localparam logic [ADDR_W-1:0] XLO = ADDR_W'(XBASE);

  logic [NCH-1:0]    din_s;
  logic              cyc_fin, cyc_io, cyc_wr, ext_hit, io_miss;
  logic [ADDR_W-1:0] cyc_addr, xoff;
  logic [1:0]        cyc_be;
  logic [15:0]       rd_word;

  din_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(din_raw), .synced(din_s)
  );

  bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .id_sel(id_sel), .wr(wr),
    .addr(addr), .be(be), .wdata(wdata), .cyc_fin(cyc_fin), .ack(ack),
    .cyc_io(cyc_io), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_be(cyc_be),
    .cyc_wdata(ext_wdata)
  );

  reg_read #(
    .NCH(NCH), .ADDR_W(ADDR_W), .XBASE(XBASE), .NXREG(NXREG), .ID_TAG(ID_TAG),
    .ID_VENDOR(ID_VENDOR), .ID_MODEL(ID_MODEL), .ID_REV(ID_REV), .ID_DRV(ID_DRV),
    .ID_USED(ID_USED)
  ) u_read (
    .din(din_s), .cyc_io(cyc_io), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr),
    .cyc_be(cyc_be), .ext_rdata(ext_rdata), .ext_hit(ext_hit), .io_miss(io_miss),
    .rd_word(rd_word)
  );

  assign xoff    = cyc_addr - XLO;
  assign ext_idx = xoff[XIDX_W-1:0];
  assign ext_be  = cyc_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      ext_we <= 1'b0;
    end else begin
      ext_we <= cyc_fin && cyc_wr && ext_hit;
      if (cyc_fin) rdata <= rd_word;
    end
  end

  // R6
  ext_we_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> ack);
  // R4
  pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cyc_io && !cyc_wr && cyc_addr == LASTW && cyc_be == 2'b11)
      |-> ((rdata & PADM) == PADM));
  // R5
  miss_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && io_miss && !cyc_wr) |-> rdata[15:12] == 4'h0);
  // R8
  id_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cyc_io) |-> rdata[15:8] == 8'h00);
  // R10
  write_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cyc_wr) |-> rdata == 16'h0000);
endmodule

// File: tb/tb_dinreg_port.sv
`timescale 1ns/1ps
module tb_dinreg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] din = '0;
  logic        io_sel = 1'b0, id_sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, ext_wdata, ext_rdata;
  logic        ack, ext_we;
  logic [2:0]  ext_idx;
  logic [1:0]  ext_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign ext_rdata = 16'hB700 | {13'd0, ext_idx};

  dinreg_port dut (
    .clk(clk), .rst_n(rst_n), .din_raw(din), .io_sel(io_sel), .id_sel(id_sel),
    .wr(wr), .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .ack(ack),
    .ext_idx(ext_idx), .ext_we(ext_we), .ext_wdata(ext_wdata), .ext_be(ext_be),
    .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] b);
    logic [15:0] m;
    m = {{8{b[1]}}, {8{b[0]}}};
    return w & m;
  endfunction

  function automatic logic [15:0] exp_io(input int a, input logic [1:0] b, input logic [39:0] d);
    logic [15:0] w;
    logic [47:0] wide;
    wide = {8'h00, d};
    if (a < 3) begin
      w = wide[a*16 +: 16];
      if (a == 2) w = w | 16'hFF00;
    end else if (a >= 4 && a <= 9) w = 16'hB700 + 16'(a - 4);
    else w = 16'h0FFF;
    return lanes(w, b);
  endfunction

  function automatic logic [7:0] exp_id(input int n);
    string tag = "DINP";
    if (n < 4) return tag[n];
    case (n)
      4: return 8'h5A;
      5: return 8'h27;
      6: return 8'h01;
      8: return 8'h31;
      10: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input int a);
    if (a == 0) return "R2";
    if (a == 1) return "R3";
    if (a == 2) return "R4";
    if (a >= 4 && a <= 9) return "R6";
    return "R5";
  endfunction

  // Caller stands at a falling edge; returns at a falling edge.
  task automatic access(input bit io, input bit w, input int a, input logic [1:0] b,
                        input logic [15:0] wd, output logic [15:0] rd, output logic we_seen);
    logic t0, t1, t2;
    io_sel = io; id_sel = !io; wr = w; addr = 6'(a); be = b; wdata = wd;
    @(negedge clk); t0 = ack;
    @(negedge clk); t1 = ack; rd = rdata; we_seen = ext_we;
    io_sel = 1'b0; id_sel = 1'b0; wr = 1'b0;
    @(negedge clk); t2 = ack;
    chk("R9 ack timing", {13'd0, t0, t1, t2}, 16'h0002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        we;
    logic [39:0] pats [3];
    pats[0] = 40'h00_0000_0000;
    pats[1] = 40'hFF_FFFF_FFFF;
    pats[2] = 40'h96_C3A5_5A3C;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ack", {15'd0, ack}, 16'h0000);
    chk("R11 rdata", rdata, 16'h0000);
    chk("R11 ext_we", {15'd0, ext_we}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweeps over input patterns, all I/O addresses and lane choices (R2..R7)
    for (int p = 0; p < 3; p++) begin
      din = pats[p];
      repeat (3) @(negedge clk);
      for (int a = 0; a < 64; a++) begin
        for (int bi = 1; bi < 4; bi++) begin
          access(1'b1, 1'b0, a, 2'(bi), 16'h0, rd, we);
          chk({req_of(a), (bi != 3) ? " R7 lane" : ""}, rd, exp_io(a, 2'(bi), din));
          if (a >= 4 && a <= 9) chk("R6 no we on read", {15'd0, we}, 16'h0000);
        end
      end
    end

    // Walking one over every channel (R2 R3 R4)
    for (int ch = 0; ch < 40; ch++) begin
      din = 40'd1 << ch;
      repeat (3) @(negedge clk);
      access(1'b1, 1'b0, ch / 16, 2'b11, 16'h0, rd, we);
      chk(req_of(ch / 16), rd, exp_io(ch / 16, 2'b11, din));
    end

    // ID space sweep (R8, R7)
    for (int a = 0; a < 64; a++) begin
      access(1'b0, 1'b0, a, 2'b11, 16'h0, rd, we);
      chk("R8 id word", rd, {8'h00, exp_id(a)});
      if (a < 12) begin
        access(1'b0, 1'b0, a, 2'b10, 16'h0, rd, we);
        chk("R7 id high lane", rd, 16'h0000);
      end
    end

    // Writes to read-only locations (R10)
    din = 40'h12_3456_789A;
    repeat (3) @(negedge clk);
    access(1'b1, 1'b1, 0, 2'b11, 16'h5555, rd, we);
    chk("R10 wr data", rd, 16'h0000);
    chk("R10 wr no we", {15'd0, we}, 16'h0000);
    access(1'b1, 1'b1, 2, 2'b11, 16'h0000, rd, we);
    chk("R10 wr data", rd, 16'h0000);
    access(1'b1, 1'b1, 12, 2'b01, 16'hFFFF, rd, we);
    chk("R10 wr no we", {15'd0, we}, 16'h0000);
    access(1'b0, 1'b1, 0, 2'b11, 16'hAAAA, rd, we);
    chk("R10 id wr no we", {15'd0, we}, 16'h0000);
    access(1'b1, 1'b0, 0, 2'b11, 16'h0, rd, we);
    chk("R10 word A unchanged", rd, 16'h789A);
    access(1'b1, 1'b0, 2, 2'b11, 16'h0, rd, we);
    chk("R10 word C unchanged", rd, 16'hFF12);
    access(1'b0, 1'b0, 0, 2'b11, 16'h0, rd, we);
    chk("R10 id unchanged", rd, 16'h0044);

    // Write into the interrupt window (R6)
    io_sel = 1'b1; wr = 1'b1; addr = 6'd7; be = 2'b10; wdata = 16'hC0DE;
    @(negedge clk);
    chk("R6 ext_idx", {13'd0, ext_idx}, 16'd3);
    chk("R6 ext_we early", {15'd0, ext_we}, 16'h0000);
    @(negedge clk);
    chk("R6 ext_we", {15'd0, ext_we}, 16'h0001);
    chk("R6 ext_wdata", ext_wdata, 16'hC0DE);
    chk("R6 ext_be", {14'd0, ext_be}, 16'h0002);
    io_sel = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk("R6 ext_we single", {15'd0, ext_we}, 16'h0000);

    // Held select gives one acknowledge (R9)
    begin
      int n_ack;
      n_ack = 0;
      io_sel = 1'b1; addr = 6'd1; be = 2'b11;
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        if (ack) n_ack++;
      end
      io_sel = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        if (ack) n_ack++;
      end
      chk("R9 one ack per select", 16'(n_ack), 16'd1);
    end

    // Synchronizer latency (R1)
    din = 40'h00_0000_0000;
    repeat (3) @(negedge clk);
    din = 40'h00_0000_BEEF;
    access(1'b1, 1'b0, 0, 2'b11, 16'h0, rd, we);
    chk("R1 old value", rd, 16'h0000);
    access(1'b1, 1'b0, 0, 2'b11, 16'h0, rd, we);
    chk("R1 new value", rd, 16'hBEEF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule